// File: doc/BRIEF.md
# Host-to-DSP Control and Status Register

This block is one 8-bit register that a host microcontroller uses to control a DSP coprocessor beside it. The host's system clock comes from this block. It divides the oscillator by 2, 4 or 8. A new divisor is applied only at the point where every divider stage is low, so the system clock never has a shortened pulse.

The register also controls the DSP's power and reset. One field enables the DSP clock. Clearing it halts the DSP, and setting it lets the DSP resume from where it stopped. A write-one action sends the DSP a reset pulse of fixed length and also returns the DSP to the running state.

Two interrupt flags carry requests between the host and the DSP. The host sets the request toward the DSP, and the DSP clears it with an acknowledge pulse. The DSP sets the request toward the host, and the host clears it by writing one. In both flags, a set arriving in the same cycle as a clear wins.

All register accesses run on the oscillator clock. A write is taken on any rising edge where the write enable is high, and every field is written at once. Read data is combinational.

Top module: `hcp_ctrl_reg`

## Requirements
- R1: After reset, the register reads 0x10 (divisor field 00, run 1, all other bits 0). The DSP clock enable is 1, the DSP reset and both interrupts are 0, and the system clock period is 8 oscillator cycles.
- R2: Bits 7:6 select the system clock period in oscillator cycles: 00 gives 8, 01 gives 4, and 10 or 11 gives 2. They read back as written.
- R3: A new divisor takes effect only on the edge where the divider count wraps to zero. Every high phase and every low phase of the system clock therefore lasts 1, 2 or 4 oscillator cycles.
- R4: Writing 1 to bit 5 drives the DSP reset high for exactly 4 oscillator cycles, starting with the edge of the write. Bit 5 always reads 0, and writing 0 to it has no effect.
- R5: Bit 4 is the run control. It reads back as written, and the DSP clock enable equals it from the edge of the write.
- R6: A write with bit 5 set leaves bit 4 at 1, even if the same write holds 0 in bit 4.
- R7: Bits 3:2 read as 0, and writes to them are ignored.
- R8: Writing 1 to bit 1 sets the interrupt to the DSP. Writing 0 to bit 1 has no effect. Bit 1 reads the state of this interrupt, and a pulse on the DSP acknowledge input clears it.
- R9: If the host writes 1 to bit 1 in the same cycle as the DSP acknowledge, the interrupt to the DSP stays set.
- R10: A pulse on the DSP-side set input raises the host interrupt, and bit 0 reads it. Writing 1 to bit 0 clears the host interrupt. Writing 0 to bit 0 has no effect.
- R11: If the DSP-side set input and a write of 1 to bit 0 occur in the same cycle, the host interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| sys_clk | output | 1 | Divided host system clock |
| dsp_clk_en | output | 1 | DSP clock enable (run state) |
| dsp_rst | output | 1 | DSP reset pulse |
| dsp_irq | output | 1 | Interrupt request to the DSP |
| dsp_irq_ack | input | 1 | DSP acknowledge; clears dsp_irq |
| host_irq_set | input | 1 | DSP request to raise the host interrupt |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The bench targets three kinds of corner case.

The first is the same-cycle collisions on both interrupt flags. A design with the priority reversed would drop a request that arrives as the previous one is being cleared.

The second is a reset write that also clears bit 4. A design that let the run field win would leave the DSP halted during and after its reset.

The third covers the divisor changes made at arbitrary points in the count, and the reset pulse length. The bench measures the length of every phase of the system clock. A divider that switched at once would produce runts of 3 cycles or of odd lengths. The bench also counts the reset pulse one cycle at a time, so a pulse that is one cycle long or short is reported.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int REG_W      = 8;
  localparam int SEL_W      = 2;
  localparam int DIV_STAGES = 3;
  localparam int RST_LEN    = 4;

  // field positions; the host software decodes these
  localparam int F_HOST_IRQ = 0;
  localparam int F_DSP_IRQ  = 1;
  localparam int F_RUN      = 4;
  localparam int F_DSP_RST  = 5;
  localparam int F_SEL_LO   = 6;

  typedef logic [SEL_W-1:0] div_sel_t;

  // divider stage whose output becomes the system clock
  function automatic int unsigned tap_for_sel(input div_sel_t sel);
    if (sel[1])      return 0;   // /2
    else if (sel[0]) return 1;   // /4
    else             return 2;   // /8
  endfunction

  // full system clock period in oscillator cycles
  function automatic int unsigned period_for_sel(input div_sel_t sel);
    return 2 << tap_for_sel(sel);
  endfunction

  // assemble the read image from the live fields
  function automatic logic [REG_W-1:0] read_image(input div_sel_t sel,
                                                  input logic run,
                                                  input logic dsp_irq,
                                                  input logic host_irq);
    logic [REG_W-1:0] img;
    img = '0;
    img[F_SEL_LO +: SEL_W] = sel;
    img[F_RUN]             = run;
    img[F_DSP_IRQ]         = dsp_irq;
    img[F_HOST_IRQ]        = host_irq;
    return img;
  endfunction
endpackage

// File: rtl/hcp_clk_div.sv
module hcp_clk_div
  import hcp_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_t sel_req,
  output div_sel_t sel_act,
  output logic     wrap,
  output logic     sys_clk
);
  localparam int TAP_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [STAGES-1:0] cnt_q;
  div_sel_t          act_q;
  logic [TAP_W-1:0]  tap;

  // every stage is high just before the count rolls over to all-zero
  assign wrap = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (wrap) act_q <= sel_req;
  end

  assign tap     = TAP_W'(tap_for_sel(act_q));
  assign sel_act = act_q;
  assign sys_clk = cnt_q[tap];

  p_switch_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(wrap));
  p_sys_low_after_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !sys_clk);
endmodule

// File: rtl/hcp_rst_pulse.sv
module hcp_rst_pulse #(
  parameter int LEN = hcp_pkg::RST_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trig)          cnt_q <= CW'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse = (cnt_q != '0);

  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);
  p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && !trig) |=> !pulse);
endmodule

// File: rtl/hcp_irq_flag.sv
module hcp_irq_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  generate
    if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
      end
    end else begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (clr) flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
      end
    end
  endgenerate

  assign flag = flag_q;

  p_set_takes_r9_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set && SET_WINS) |=> flag);
  p_clear_takes_r8_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  p_hold_r8_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/hcp_ctrl_reg.sv
module hcp_ctrl_reg
  import hcp_pkg::*;
(
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sys_clk,
  output logic             dsp_clk_en,
  output logic             dsp_rst,
  output logic             dsp_irq,
  input  logic             dsp_irq_ack,
  input  logic             host_irq_set,
  output logic             host_irq
);
  div_sel_t sel_q;
  div_sel_t sel_act;
  logic     run_q;
  logic     div_wrap;

  // named write events, used by the logic and by the assertions
  logic ev_rst_dsp;
  logic ev_set_dsp_irq;
  logic ev_clr_host_irq;

  assign ev_rst_dsp      = wr_en && wr_data[F_DSP_RST];
  assign ev_set_dsp_irq  = wr_en && wr_data[F_DSP_IRQ];
  assign ev_clr_host_irq = wr_en && wr_data[F_HOST_IRQ];

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data[F_SEL_LO +: SEL_W];
  end

  // a DSP reset always leaves the DSP running
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 1'b1;
    else if (ev_rst_dsp) run_q <= 1'b1;
    else if (wr_en)      run_q <= wr_data[F_RUN];
  end

  hcp_clk_div #(.STAGES(DIV_STAGES)) u_div (
    .clk(osc_clk), .rst_n(rst_n), .sel_req(sel_q),
    .sel_act(sel_act), .wrap(div_wrap), .sys_clk(sys_clk)
  );

  hcp_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk(osc_clk), .rst_n(rst_n), .trig(ev_rst_dsp), .pulse(dsp_rst)
  );

  hcp_irq_flag #(.SET_WINS(1'b1)) u_to_dsp (
    .clk(osc_clk), .rst_n(rst_n), .set(ev_set_dsp_irq),
    .clr(dsp_irq_ack), .flag(dsp_irq)
  );

  hcp_irq_flag #(.SET_WINS(1'b1)) u_to_host (
    .clk(osc_clk), .rst_n(rst_n), .set(host_irq_set),
    .clr(ev_clr_host_irq), .flag(host_irq)
  );

  assign dsp_clk_en = run_q;
  assign rd_data    = read_image(sel_q, run_q, dsp_irq, host_irq);

  p_sel_readback_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wr_en |=> rd_data[F_SEL_LO +: SEL_W] == $past(wr_data[F_SEL_LO +: SEL_W]));
  p_run_follows_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (wr_en && !wr_data[F_DSP_RST]) |=> dsp_clk_en == $past(wr_data[F_RUN]));
  p_reset_runs_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ev_rst_dsp |=> (dsp_clk_en && dsp_rst));
  p_run_hold_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !wr_en |=> $stable(dsp_clk_en));
  p_rsvd_quiet_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wr_en |=> (rd_data[3:2] == 2'b00 && !rd_data[F_DSP_RST]));
endmodule

// File: tb/hcp_ctrl_reg_test.sv
module hcp_ctrl_reg_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  NV = 22;

  logic       osc_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       dsp_irq_ack  = 1'b0;
  logic       host_irq_set = 1'b0;
  logic [7:0] rd_data;
  logic       sys_clk, dsp_clk_en, dsp_rst, dsp_irq, host_irq;

  int vecs = 0;
  int miss = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

  hcp_ctrl_reg uut (
    .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_clk(sys_clk), .dsp_clk_en(dsp_clk_en),
    .dsp_rst(dsp_rst), .dsp_irq(dsp_irq), .dsp_irq_ack(dsp_irq_ack),
    .host_irq_set(host_irq_set), .host_irq(host_irq)
  );

  // {wr, data, host_irq_set, ack, expected read, expected dsp_rst}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'h10, 1'b0, 1'b0, 8'h10, 1'b0},
    {1'b1, 8'h12, 1'b0, 1'b0, 8'h12, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0},
    {1'b1, 8'h12, 1'b0, 1'b1, 8'h12, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b1, 8'h10, 1'b0, 1'b0, 8'h11, 1'b0},
    {1'b1, 8'h11, 1'b0, 1'b0, 8'h10, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b1, 8'h11, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b1, 8'h11, 1'b0, 1'b0, 8'h10, 1'b0},
    {1'b1, 8'h1C, 1'b0, 1'b0, 8'h10, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h20, 1'b0, 1'b0, 8'h10, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h10, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h10, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h10, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h10, 1'b0},
    {1'b1, 8'h50, 1'b0, 1'b0, 8'h50, 1'b0},
    {1'b1, 8'h90, 1'b0, 1'b0, 8'h90, 1'b0},
    {1'b1, 8'hD0, 1'b0, 1'b0, 8'hD0, 1'b0},
    {1'b1, 8'h10, 1'b0, 1'b0, 8'h10, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R5", "R8", "R8", "R9", "R8", "R10", "R10", "R10", "R10", "R11", "R10",
    "R7", "R5", "R6", "R4", "R4", "R4", "R4", "R2", "R2", "R2", "R2"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // phase-length monitor on the system clock
  bit mon_on = 1'b0;
  bit mon_valid = 1'b0;
  int run_len = 0;
  int bad_phase = 0;
  logic last_sc = 1'b0;
  always @(negedge osc_clk) begin
    if (mon_on) begin
      if (sys_clk === last_sc) run_len++;
      else begin
        if (mon_valid && !(run_len == 1 || run_len == 2 || run_len == 4)) bad_phase++;
        mon_valid = 1'b1;
        run_len = 1;
        last_sc = sys_clk;
      end
    end
  end

  task automatic write_reg(input logic [7:0] d);
    @(negedge osc_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge osc_clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic measure(output int per);
    logic prev;
    int n;
    prev = sys_clk;
    forever begin
      @(negedge osc_clk);
      if (!prev && sys_clk) break;
      prev = sys_clk;
    end
    n = 0;
    prev = sys_clk;
    forever begin
      @(negedge osc_clk);
      n++;
      if (!prev && sys_clk) break;
      prev = sys_clk;
    end
    per = n;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int per;
    repeat (3) @(negedge osc_clk);
    // R1: reset state while held in reset
    check("R1 read", 32'(rd_data), 32'h10);
    check("R1 outputs", {28'd0, dsp_clk_en, dsp_rst, dsp_irq, host_irq}, 32'b1000);
    rst_n = 1'b1;
    measure(per);
    check("R1 period", 32'(per), 32'd8);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge osc_clk);
      wr_en        = VEC[i][19];
      wr_data      = VEC[i][18:11];
      host_irq_set = VEC[i][10];
      dsp_irq_ack  = VEC[i][9];
      @(posedge osc_clk);
      #(CLK_PERIOD/4);
      check(TAG[i],
            {20'd0, rd_data, dsp_rst, dsp_clk_en, dsp_irq, host_irq},
            {20'd0, VEC[i][8:1], VEC[i][0], VEC[i][5], VEC[i][2], VEC[i][1]});
    end
    @(negedge osc_clk);
    wr_en = 1'b0; wr_data = 8'h00; host_irq_set = 1'b0; dsp_irq_ack = 1'b0;

    // R2: periods for each divisor code
    write_reg(8'h50); repeat (20) @(negedge osc_clk); measure(per);
    check("R2 div01", 32'(per), 32'd4);
    write_reg(8'h90); repeat (20) @(negedge osc_clk); measure(per);
    check("R2 div10", 32'(per), 32'd2);
    write_reg(8'hD0); repeat (20) @(negedge osc_clk); measure(per);
    check("R2 div11", 32'(per), 32'd2);
    write_reg(8'h10); repeat (20) @(negedge osc_clk); measure(per);
    check("R2 div00", 32'(per), 32'd8);

    // R3: switch at awkward points, every phase must be a legal length
    mon_on = 1'b1;
    for (int k = 0; k < 8; k++) begin
      repeat (k + 3) @(negedge osc_clk);
      write_reg(8'hD0);
      repeat (k + 5) @(negedge osc_clk);
      write_reg(8'h10);
      repeat (k + 1) @(negedge osc_clk);
      write_reg(8'h50);
    end
    repeat (30) @(negedge osc_clk);
    mon_on = 1'b0;
    check("R3 phases", 32'(bad_phase), 32'd0);

    // R4: writing 0 to bit 5 produces no pulse
    write_reg(8'h10);
    check("R4 no pulse", {31'd0, dsp_rst}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule